// File: doc/BRIEF.md
# Address Guard and Relocation Unit

This unit sits between a processor's address output and the system bus. Every access request carries an address, a privilege flag and a scheme selector. Supervisor accesses go through unchecked. User accesses are tested against a set of guard registers under one of three schemes. In the first scheme one lower boundary fences off the protected region below it. In the second, a window is bounded on both sides. In the third, the incoming address is a logical offset: it is checked against a length and then moved up by a base to form the physical address. A user access that fails its test produces a one-cycle trap pulse, and no bus strobe is issued for it.

The guard registers are loaded through a write port that only privileged code may use. This models the kernel reprogramming the unit when it switches from one process to another. The lower fence boundary can be loaded once after reset; later loads leave it unchanged. A write attempted from user mode changes nothing and is reported as a trap. Results come out of a single register stage. The unit accepts one request per cycle and returns one result per request.

Top module: `xlate_guard`

## Requirements
- R1: After reset, ack_o, bus_valid_o and trap_o are low and paddr_o is zero. The guard registers start at these values: fence 0, low 0, high all ones, base 0, limit all ones.
- R2: In mode 0 (fence), a user access whose address is below the fence register traps. Any other user access is forwarded with paddr_o equal to the input address.
- R3: In mode 1 (window), a user access traps if its address is below the low register or above the high register. An address inside both bounds, with the bounds inclusive, is forwarded unchanged.
- R4: In mode 2 (relocate), a user access traps if its address is greater than the limit register. Otherwise paddr_o is the address plus the base register.
- R5: With WRAP_ADD=0 (the default), a mode-2 user access whose address plus base carries out of AW bits traps instead of wrapping.
- R6: A supervisor access (priv_i=1) in any mode is forwarded with paddr_o equal to addr_i and never traps.
- R7: Whenever bus_valid_o is low, paddr_o is zero. trap_o and bus_valid_o are never high in the same cycle.
- R8: Each cycle in which req_i is high gives exactly one result: ack_o is high in the following cycle. Back-to-back requests give back-to-back results. ack_o is low after a cycle without a request.
- R9: The fence register (wr_sel_i=0) takes only the first supervisor write after reset. Later writes to it have no effect.
- R10: A write with priv_i=0 changes no register and raises trap_o in the next cycle. A user access presented in that same cycle is suppressed. The other selects are 1 low, 2 high, 3 base and 4 limit; selects 5 to 7 change nothing.
- R11: Mode 3 is reserved: every user access in it traps.
- R12: In a cycle without a request and without a user write, the next cycle shows ack_o, bus_valid_o and trap_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| priv_i | input | 1 | 1 = supervisor, 0 = user (applies to access and write) |
| mode_i | input | 2 | Scheme: 0 fence, 1 window, 2 relocate, 3 reserved |
| addr_i | input | AW | Access address (logical in mode 2) |
| wr_en_i | input | 1 | Guard register write strobe |
| wr_sel_i | input | 3 | Register select: 0 fence, 1 low, 2 high, 3 base, 4 limit |
| wr_data_i | input | AW | Value to load |
| ack_o | output | 1 | Result for the previous cycle's request |
| bus_valid_o | output | 1 | Forward paddr_o to the bus |
| paddr_o | output | AW | Physical address, zero when not valid |
| trap_o | output | 1 | Illegal access or illegal write pulse |

## Verification
Every result appears exactly one clock edge after the inputs that cause it: access outcomes, write traps and the ack all pass through one register stage. A register write takes effect for accesses presented after that edge. The bench drives each stimulus on the falling edge, waits for the next rising edge, and samples shortly after it. Expected values come from arithmetic on a shadow copy of the registers the bench has loaded. Sweeps cover every address of an 8-bit configuration in each scheme, so each comparison boundary and the carry edge are tested on both sides.

// File: rtl/xg_pkg.sv
package xg_pkg;
   typedef enum logic [1:0] {
      XG_FENCE   = 2'd0,
      XG_WINDOW  = 2'd1,
      XG_RELOC   = 2'd2,
      XG_RSVD    = 2'd3
   } xg_mode_e;

   typedef enum logic [2:0] {
      SEL_FENCE = 3'd0,
      SEL_LOW   = 3'd1,
      SEL_HIGH  = 3'd2,
      SEL_BASE  = 3'd3,
      SEL_LIMIT = 3'd4
   } xg_sel_e;

   localparam int XG_NREG = 5;
endpackage

// File: rtl/xg_regs.sv
module xg_regs
   import xg_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic          wr_priv_i,
   input  logic [2:0]    wr_sel_i,
   input  logic [AW-1:0] wr_data_i,
   output logic [AW-1:0] fence_o,
   output logic [AW-1:0] low_o,
   output logic [AW-1:0] high_o,
   output logic [AW-1:0] base_o,
   output logic [AW-1:0] limit_o,
   output logic          wr_fault_o
);
   logic [AW-1:0] val_q [XG_NREG];
   logic          fence_lock_q;
   logic          wr_ok;

   assign wr_ok      = wr_en_i & wr_priv_i;
   assign wr_fault_o = wr_en_i & ~wr_priv_i;

   for (genvar g = 0; g < XG_NREG; g++) begin : g_reg
      localparam bit IS_TOP   = (g == int'(SEL_HIGH)) || (g == int'(SEL_LIMIT));
      localparam bit IS_FENCE = (g == int'(SEL_FENCE));
      localparam logic [AW-1:0] RST_VAL = IS_TOP ? {AW{1'b1}} : {AW{1'b0}};
      logic hit;
      if (IS_FENCE) begin : g_once
         assign hit = wr_ok && (wr_sel_i == 3'(g)) && !fence_lock_q;
      end else begin : g_free
         assign hit = wr_ok && (wr_sel_i == 3'(g));
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   val_q[g] <= RST_VAL;
         else if (hit) val_q[g] <= wr_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               fence_lock_q <= 1'b0;
      else if (wr_ok && wr_sel_i == SEL_FENCE) fence_lock_q <= 1'b1;
   end

   assign fence_o = val_q[int'(SEL_FENCE)];
   assign low_o   = val_q[int'(SEL_LOW)];
   assign high_o  = val_q[int'(SEL_HIGH)];
   assign base_o  = val_q[int'(SEL_BASE)];
   assign limit_o = val_q[int'(SEL_LIMIT)];
endmodule

// File: rtl/xg_check.sv
module xg_check
   import xg_pkg::*;
#(
   parameter int AW       = 32,
   parameter bit WRAP_ADD = 1'b0
) (
   input  logic [1:0]    mode_i,
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] fence_i,
   input  logic [AW-1:0] low_i,
   input  logic [AW-1:0] high_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] limit_i,
   output logic          deny_o,
   output logic [AW-1:0] phys_o
);
   logic [AW-1:0] sum;
   logic          carry;

   if (WRAP_ADD) begin : g_wrap
      assign sum   = addr_i + base_i;
      assign carry = 1'b0;
   end else begin : g_strict
      logic [AW:0] wide;
      assign wide  = {1'b0, addr_i} + {1'b0, base_i};
      assign sum   = wide[AW-1:0];
      assign carry = wide[AW];
   end

   always_comb begin
      deny_o = 1'b1;
      phys_o = addr_i;
      unique case (xg_mode_e'(mode_i))
         XG_FENCE:  deny_o = addr_i < fence_i;
         XG_WINDOW: deny_o = (addr_i < low_i) || (addr_i > high_i);
         XG_RELOC: begin
            deny_o = (addr_i > limit_i) || carry;
            phys_o = sum;
         end
         default:   deny_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/xg_stage.sv
module xg_stage #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          deny_i,
   input  logic          fault_i,
   input  logic [AW-1:0] phys_i,
   output logic          ack_o,
   output logic          valid_o,
   output logic          trap_o,
   output logic [AW-1:0] paddr_o
);
   logic fire;
   assign fire = req_i & ~deny_i & ~fault_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o   <= 1'b0;
         valid_o <= 1'b0;
         trap_o  <= 1'b0;
         paddr_o <= '0;
      end else begin
         ack_o   <= req_i;
         valid_o <= fire;
         trap_o  <= (req_i & deny_i) | fault_i;
         paddr_o <= fire ? phys_i : '0;
      end
   end
endmodule

// File: rtl/xlate_guard.sv
module xlate_guard #(
   parameter int AW       = 32,
   parameter bit WRAP_ADD = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          priv_i,
   input  logic [1:0]    mode_i,
   input  logic [AW-1:0] addr_i,
   input  logic          wr_en_i,
   input  logic [2:0]    wr_sel_i,
   input  logic [AW-1:0] wr_data_i,
   output logic          ack_o,
   output logic          bus_valid_o,
   output logic [AW-1:0] paddr_o,
   output logic          trap_o
);
   if (AW < 4 || AW > 64) begin : g_bad_aw
      $error("xlate_guard: AW must lie in 4..64");
   end

   logic [AW-1:0] fence, low, high, base, limit, chk_phys, out_phys;
   logic          wr_fault, chk_deny, user_deny;

   xg_regs #(.AW(AW)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_priv_i(priv_i),
      .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .fence_o(fence), .low_o(low), .high_o(high), .base_o(base),
      .limit_o(limit), .wr_fault_o(wr_fault)
   );

   xg_check #(.AW(AW), .WRAP_ADD(WRAP_ADD)) i_check (
      .mode_i(mode_i), .addr_i(addr_i), .fence_i(fence), .low_i(low),
      .high_i(high), .base_i(base), .limit_i(limit),
      .deny_o(chk_deny), .phys_o(chk_phys)
   );

   assign user_deny = ~priv_i & chk_deny;
   assign out_phys  = priv_i ? addr_i : chk_phys;

   xg_stage #(.AW(AW)) i_stage (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .deny_i(user_deny),
      .fault_i(wr_fault), .phys_i(out_phys),
      .ack_o(ack_o), .valid_o(bus_valid_o), .trap_o(trap_o), .paddr_o(paddr_o)
   );
endmodule

// File: rtl/xg_checker.sv
module xg_checker #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_i,
   input logic          priv_i,
   input logic [1:0]    mode_i,
   input logic [AW-1:0] addr_i,
   input logic          wr_en_i,
   input logic          ack_o,
   input logic          bus_valid_o,
   input logic [AW-1:0] paddr_o,
   input logic          trap_o
);
   p_ack_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> ack_o);
   p_no_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !ack_o);
   p_valid_needs_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o |-> ack_o);
   p_trap_kills_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> !bus_valid_o);
   p_paddr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid_o |-> paddr_o == '0);
   p_super_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && priv_i) |=> (bus_valid_o && !trap_o && paddr_o == $past(addr_i)));
   p_user_wr_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !priv_i) |=> (trap_o && !bus_valid_o));
   p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !priv_i && mode_i == 2'd3) |=> trap_o);
endmodule

bind xlate_guard xg_checker #(.AW(AW)) i_xg_checker (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .priv_i(priv_i), .mode_i(mode_i),
   .addr_i(addr_i), .wr_en_i(wr_en_i), .ack_o(ack_o), .bus_valid_o(bus_valid_o),
   .paddr_o(paddr_o), .trap_o(trap_o)
);

// File: tb/test_xlate_guard.sv
`timescale 1ns/1ps
module test_xlate_guard;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0, priv_i = 1'b0, wr_en_i = 1'b0;
   logic [1:0]    mode_i = 2'd0;
   logic [AW-1:0] addr_i = '0, wr_data_i = '0;
   logic [2:0]    wr_sel_i = 3'd0;
   logic          ack_o, bus_valid_o, trap_o;
   logic [AW-1:0] paddr_o;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // shadow registers held by the bench
   int sh_fence = 0, sh_low = 0, sh_high = 255, sh_base = 0, sh_limit = 255;
   bit sh_locked = 1'b0;

   always #2.5 clk = ~clk;

   xlate_guard #(.AW(AW)) i_xlate_guard (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .priv_i(priv_i), .mode_i(mode_i),
      .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .ack_o(ack_o), .bus_valid_o(bus_valid_o), .paddr_o(paddr_o), .trap_o(trap_o)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(int mode, bit priv, int addr, string req);
      int  ep;
      bit  et;
      @(negedge clk);
      wr_en_i = 1'b0; req_i = 1'b1; priv_i = priv; mode_i = 2'(mode); addr_i = 8'(addr);
      ep = addr;
      et = 1'b0;
      if (!priv) begin
         case (mode)
            0: et = addr < sh_fence;
            1: et = (addr < sh_low) || (addr > sh_high);
            2: begin et = (addr > sh_limit) || (addr + sh_base > 255); ep = addr + sh_base; end
            default: et = 1'b1;
         endcase
      end
      @(posedge clk); #1;
      chk(req, {ack_o, trap_o, bus_valid_o, paddr_o},
          {1'b1, et, !et, et ? 8'h00 : 8'(ep)});
   endtask

   task automatic write_reg(int sel, int data, bit priv, string req);
      @(negedge clk);
      req_i = 1'b0; wr_en_i = 1'b1; priv_i = priv; wr_sel_i = 3'(sel); wr_data_i = 8'(data);
      @(posedge clk); #1;
      chk(req, {trap_o, ack_o, bus_valid_o}, {!priv, 2'b00});
      if (priv) begin
         case (sel)
            0: if (!sh_locked) begin sh_fence = data; sh_locked = 1'b1; end
            1: sh_low = data;
            2: sh_high = data;
            3: sh_base = data;
            4: sh_limit = data;
            default: ;
         endcase
      end
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic idle(string req);
      @(negedge clk);
      req_i = 1'b0; wr_en_i = 1'b0;
      @(posedge clk); #1;
      chk(req, {ack_o, bus_valid_o, trap_o, paddr_o}, 0);
   endtask

   task automatic sweep(int mode, bit priv, string req);
      for (int a = 0; a < 256; a++) access(mode, priv, a, req);
      idle("R8 idle after burst");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #12 rst_n = 1'b1;
      #1;
      // R1: reset state at the ports
      chk("R1 reset outputs", {ack_o, bus_valid_o, trap_o, paddr_o}, 0);
      // R1: reset register values seen through the access path
      access(1, 1'b0, 0, "R1 reset low/high window");
      access(1, 1'b0, 255, "R1 reset low/high window");
      access(2, 1'b0, 255, "R1 reset limit/base");
      access(0, 1'b0, 0, "R1 reset fence");
      idle("R12 no request");
      // R2 fence sweep
      write_reg(0, 8'h40, 1'b1, "R2 fence load");
      sweep(0, 1'b0, "R2 fence mode");
      // R9 second fence write ignored
      write_reg(0, 8'h80, 1'b1, "R9 fence reload");
      sweep(0, 1'b0, "R9 fence write-once");
      // R3 window sweep
      write_reg(1, 8'h20, 1'b1, "R3 low load");
      write_reg(2, 8'hC0, 1'b1, "R3 high load");
      sweep(1, 1'b0, "R3 window mode");
      // R4/R5 relocate sweep: limit E0, base 30, carry from D0
      write_reg(3, 8'h30, 1'b1, "R4 base load");
      write_reg(4, 8'hE0, 1'b1, "R4 limit load");
      sweep(2, 1'b0, "R4 R5 relocate mode");
      // R10 user writes ignored and trap
      write_reg(4, 8'h10, 1'b0, "R10 user write trap");
      write_reg(3, 8'h00, 1'b0, "R10 user write trap");
      write_reg(7, 8'h00, 1'b1, "R10 unused select");
      sweep(2, 1'b0, "R10 registers unchanged");
      // R10 user write with concurrent access suppresses it
      @(negedge clk);
      req_i = 1'b1; priv_i = 1'b0; mode_i = 2'd2; addr_i = 8'h05;
      wr_en_i = 1'b1; wr_sel_i = 3'd3; wr_data_i = 8'h11;
      @(posedge clk); #1;
      chk("R10 access suppressed", {ack_o, trap_o, bus_valid_o, paddr_o}, {3'b110, 8'h00});
      idle("R12 after suppressed access");
      access(2, 1'b0, 5, "R10 base unchanged");
      // R11 reserved mode
      for (int a = 0; a < 256; a += 17) access(3, 1'b0, a, "R11 reserved mode");
      // R6 supervisor bypass in every mode
      for (int m = 0; m < 4; m++)
         for (int a = 0; a < 256; a += 5) access(m, 1'b1, a, "R6 supervisor bypass");
      idle("R8 R12 final idle");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule